// File: doc/BRIEF.md
# Set/Clear Aliased Interrupt Register Bank

This block holds the enable masks and priority levels of an interrupt controller behind a simple memory-mapped bus. A register is reached at a plain address, or through a pair of aliases: one alias ORs the written data into the stored value and the other clears the written bits. Software can therefore change single enables without a read-modify-write. The three top address bits take no part in the decode, so the bank answers in every mirrored address window.

Each mask register is a row of one-bit fields. Each priority register is a row of equal-width fields. Every field belongs to one interrupt source. After an accepted write the bank compares the old and new contents field by field. It then reports each field that changed as a one-cycle event, carrying the source number and whether the field is now nonzero. Downstream arbitration uses these events to keep its per-source enable state current. While events are still being issued, the bank is busy and discards writes.

Top module: `irq_alias_bank`

## Requirements
- R1: The decode ignores address bits 31:29; an address that differs from a register address only in those bits reaches the same register.
- R2: A write to the set alias (register address) of a dual-alias register stores old OR data.
- R3: A write to the clear alias (register address + 4) of a dual-alias register stores old AND NOT data.
- R4: The last NUM_PLAIN priority registers have only a plain address (base + index*stride) and store the written data unchanged.
- R5: Field 0 sits at the most significant end of a register. Mask register m has REG_W one-bit fields with source m*REG_W+k. Priority register p has REG_W/PRIO_FW fields with source NUM_MASK*REG_W+p*(REG_W/PRIO_FW)+k.
- R6: A field whose value is unchanged raises no event. A changed field raises one event with evt_on equal to 1 when the new field value is nonzero.
- R7: Events start in the cycle after the accepted write, one per clock, in rising field order. busy is high exactly while events remain, so a write that changes no field never raises busy.
- R8: A write presented while busy is high is discarded.
- R9: A read through the set alias, the clear alias or the plain address returns the stored value on rdata in the cycle after rd_en. A read of an unmapped address returns zero.
- R10: An accepted write to an unmapped address changes no register and sets err, which stays set until reset.
- R11: Reset clears every register, busy, err and any pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 32 | Byte address of the access |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data, valid the cycle after rd_en |
| busy | output | 1 | Events still pending; writes are discarded |
| err | output | 1 | Sticky flag for an accepted write to an unmapped address |
| evt_valid | output | 1 | A field-change event is presented this cycle |
| evt_src | output | SRC_W | Source number of the presented event |
| evt_on | output | 1 | New field value of that source is nonzero |

## Verification
The assertions assume that wr_en, rd_en and addr have known values in every cycle after reset, and that the configured register addresses do not overlap once the top three bits are masked. The ascending-source property relies on the top gating writes with busy, and no input assumption is needed for it. The stimulus drives every input in every cycle on the falling edge and uses only the default, non-overlapping map. It deliberately issues writes while busy is high and writes to the unused address of the plain register, so both guarded paths are exercised rather than avoided.

// File: rtl/irb_pkg.sv
package irb_pkg;

    // how an access reaches a register
    typedef enum logic [1:0] {
        WM_NONE  = 2'd0,
        WM_SET   = 2'd1,
        WM_CLR   = 2'd2,
        WM_PLAIN = 2'd3
    } wmode_e;

    // address bits that take part in the decode
    localparam logic [31:0] ADDR_KEEP = 32'h1FFF_FFFF;

    // offset of the clear alias from the set alias
    localparam logic [31:0] CLR_OFFSET = 32'd4;

    function automatic logic addr_hit(input logic [31:0] a, input logic [31:0] target);
        return ((a ^ target) & ADDR_KEEP) == 32'h0;
    endfunction

endpackage

// File: rtl/irb_addr_decode.sv
module irb_addr_decode
    import irb_pkg::*;
#(
    parameter int          NUM_REGS   = 4,
    parameter int          NUM_PLAIN  = 1,
    parameter int          RIDX_W     = 2,
    parameter logic [31:0] BASE_ADDR  = 32'h0000_0400,
    parameter int          REG_STRIDE = 8
) (
    input  logic [31:0]       addr,
    output logic              hit,
    output logic [RIDX_W-1:0] idx,
    output wmode_e            mode
);

    logic [NUM_REGS-1:0] set_hit;
    logic [NUM_REGS-1:0] clr_hit;
    logic [NUM_REGS-1:0] is_dual;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [31:0] SET_A = BASE_ADDR + 32'(i * REG_STRIDE);
        localparam bit          DUAL  = (i < NUM_REGS - NUM_PLAIN);
        assign set_hit[i] = addr_hit(addr, SET_A);
        assign is_dual[i] = DUAL;
        if (DUAL) begin : g_dual
            assign clr_hit[i] = addr_hit(addr, SET_A + CLR_OFFSET);
        end else begin : g_plain
            assign clr_hit[i] = 1'b0;
        end
    end

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        mode = WM_NONE;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (set_hit[i]) begin
                hit  = 1'b1;
                idx  = RIDX_W'(i);
                mode = is_dual[i] ? WM_SET : WM_PLAIN;
            end else if (clr_hit[i]) begin
                hit  = 1'b1;
                idx  = RIDX_W'(i);
                mode = WM_CLR;
            end
        end
    end

endmodule

// File: rtl/irb_field_diff.sv
module irb_field_diff #(
    parameter int REG_W = 16,
    parameter int FW    = 1,
    localparam int NF   = REG_W / FW
) (
    input  logic [REG_W-1:0] old_v,
    input  logic [REG_W-1:0] new_v,
    output logic [NF-1:0]    changed,
    output logic [NF-1:0]    nonzero
);

    // field k occupies the k-th slice counted from the MSB
    for (genvar k = 0; k < NF; k++) begin : g_field
        localparam int HI = REG_W - 1 - k * FW;
        assign changed[k] = old_v[HI -: FW] != new_v[HI -: FW];
        assign nonzero[k] = |new_v[HI -: FW];
    end

endmodule

// File: rtl/irb_event_seq.sv
module irb_event_seq #(
    parameter int MAXF  = 16,
    parameter int SRC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [MAXF-1:0]  load_pend,
    input  logic [MAXF-1:0]  load_on,
    input  logic [SRC_W-1:0] load_base,
    output logic             busy,
    output logic             evt_valid,
    output logic [SRC_W-1:0] evt_src,
    output logic             evt_on
);

    logic [MAXF-1:0]  pending;
    logic [MAXF-1:0]  on_vec;
    logic [SRC_W-1:0] base;
    logic [MAXF-1:0]  pick;
    int               pidx;

    // lowest pending field index comes first
    assign pick = pending & (~pending + 1'b1);

    always_comb begin
        pidx = 0;
        for (int k = 0; k < MAXF; k++) begin
            if (pick[k]) pidx = k;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            on_vec  <= '0;
            base    <= '0;
        end else if (load) begin
            pending <= load_pend;
            on_vec  <= load_on;
            base    <= load_base;
        end else begin
            pending <= pending & ~pick;
        end
    end

    assign evt_valid = |pending;
    assign busy      = |pending;
    assign evt_src   = base + SRC_W'(pidx);
    assign evt_on    = |(on_vec & pick);

    AST_SRC_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> (!evt_valid || (evt_src > $past(evt_src)))); // R7

    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        load |-> !evt_valid); // R8

    AST_EVENTS_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !load) |=> ($countones(pending) < $past($countones(pending)))); // R7

endmodule

// File: rtl/irq_alias_bank.sv
module irq_alias_bank
    import irb_pkg::*;
#(
    parameter int          REG_W      = 16,
    parameter int          NUM_MASK   = 2,
    parameter int          NUM_PRIO   = 2,
    parameter int          NUM_PLAIN  = 1,
    parameter int          PRIO_FW    = 4,
    parameter logic [31:0] BASE_ADDR  = 32'h0000_0400,
    parameter int          REG_STRIDE = 8,
    localparam int NUM_REGS = NUM_MASK + NUM_PRIO,
    localparam int PNF      = REG_W / PRIO_FW,
    localparam int NUM_SRC  = NUM_MASK * REG_W + NUM_PRIO * PNF,
    localparam int SRC_W    = $clog2(NUM_SRC),
    localparam int RIDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [31:0]      addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             busy,
    output logic             err,
    output logic             evt_valid,
    output logic [SRC_W-1:0] evt_src,
    output logic             evt_on
);

    logic [NUM_REGS-1:0][REG_W-1:0] regs;

    logic              hit;
    logic [RIDX_W-1:0] ridx;
    wmode_e            mode;

    logic [REG_W-1:0]  old_v;
    logic [REG_W-1:0]  new_v;
    logic              is_mask;
    logic              wr_ok;
    logic              load;

    logic [REG_W-1:0]  chg_m, on_m;
    logic [PNF-1:0]    chg_p, on_p;
    logic [REG_W-1:0]  pend_load, on_load;
    logic [SRC_W-1:0]  base_load;

    irb_addr_decode #(
        .NUM_REGS  (NUM_REGS),
        .NUM_PLAIN (NUM_PLAIN),
        .RIDX_W    (RIDX_W),
        .BASE_ADDR (BASE_ADDR),
        .REG_STRIDE(REG_STRIDE)
    ) u_dec (
        .addr(addr),
        .hit (hit),
        .idx (ridx),
        .mode(mode)
    );

    assign old_v   = regs[ridx];
    assign is_mask = int'(ridx) < NUM_MASK;
    assign wr_ok   = wr_en && !busy;
    assign load    = wr_ok && hit;

    always_comb begin
        unique case (mode)
            WM_SET:   new_v = old_v | wdata;
            WM_CLR:   new_v = old_v & ~wdata;
            WM_PLAIN: new_v = wdata;
            default:  new_v = old_v;
        endcase
    end

    irb_field_diff #(.REG_W(REG_W), .FW(1)) u_diff_mask (
        .old_v  (old_v),
        .new_v  (new_v),
        .changed(chg_m),
        .nonzero(on_m)
    );

    irb_field_diff #(.REG_W(REG_W), .FW(PRIO_FW)) u_diff_prio (
        .old_v  (old_v),
        .new_v  (new_v),
        .changed(chg_p),
        .nonzero(on_p)
    );

    always_comb begin
        if (is_mask) begin
            pend_load = chg_m;
            on_load   = on_m;
            base_load = SRC_W'(int'(ridx) * REG_W);
        end else begin
            pend_load = REG_W'(chg_p);
            on_load   = REG_W'(on_p);
            base_load = SRC_W'(NUM_MASK * REG_W + (int'(ridx) - NUM_MASK) * PNF);
        end
    end

    irb_event_seq #(.MAXF(REG_W), .SRC_W(SRC_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_pend(pend_load),
        .load_on  (on_load),
        .load_base(base_load),
        .busy     (busy),
        .evt_valid(evt_valid),
        .evt_src  (evt_src),
        .evt_on   (evt_on)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regs  <= '0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            if (load) regs[ridx] <= new_v;
            if (wr_ok && !hit) err <= 1'b1;
            if (rd_en) rdata <= hit ? regs[ridx] : '0;
        end
    end

    AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (rst)
        (load && mode == WM_SET) |=> ((regs[$past(ridx)] & $past(old_v)) == $past(old_v))); // R2

    AST_CLR_DROPS_BITS: assert property (@(posedge clk) disable iff (rst)
        (load && mode == WM_CLR) |=> ((regs[$past(ridx)] & $past(wdata)) == '0)); // R3

    AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(regs)); // R8

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> $stable(regs)); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R10

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |=> (rdata == '0)); // R9

endmodule

// File: tb/tb_irq_alias_bank.sv
`timescale 1ns/1ps
module tb_irq_alias_bank;

    localparam int REG_W = 16;
    localparam int SRC_W = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en, rd_en;
    logic [31:0]      addr;
    logic [REG_W-1:0] wdata;
    logic [REG_W-1:0] rdata;
    logic             busy, err, evt_valid, evt_on;
    logic [SRC_W-1:0] evt_src;

    always #2 clk = ~clk;

    irq_alias_bank dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .err(err),
        .evt_valid(evt_valid), .evt_src(evt_src), .evt_on(evt_on)
    );

    // reference model state
    logic [15:0] mreg [4];
    bit          merr;
    int          evs [$];
    bit          evo [$];
    bit          rd_pend;
    logic [15:0] rd_exp;
    bit          tag_pend;
    logic [15:0] tag_exp;
    string       tag_name;
    int          checks = 0;
    int          errors = 0;

    function automatic int find_reg(input logic [31:0] a, output int mode);
        logic [31:0] ma = a & 32'h1FFF_FFFF;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] sa = 32'h400 + 32'(8 * i);
            if (ma == sa) begin
                mode = (i == 3) ? 3 : 1;
                return i;
            end
            if (i != 3 && ma == sa + 32'd4) begin
                mode = 2;
                return i;
            end
        end
        mode = 0;
        return -1;
    endfunction

    task automatic model_write(input logic [31:0] a, input logic [15:0] d);
        int mode;
        int i = find_reg(a, mode);
        logic [15:0] ov, nv;
        int fw, nf, base;
        if (i < 0) begin
            merr = 1'b1;
            return;
        end
        ov = mreg[i];
        case (mode)
            1: nv = ov | d;
            2: nv = ov & ~d;
            default: nv = d;
        endcase
        fw   = (i < 2) ? 1 : 4;
        nf   = 16 / fw;
        base = (i < 2) ? i * 16 : 32 + (i - 2) * 4;
        for (int k = 0; k < nf; k++) begin
            int sh = 16 - (k + 1) * fw;
            int o  = (int'(ov) >> sh) & ((1 << fw) - 1);
            int n  = (int'(nv) >> sh) & ((1 << fw) - 1);
            if (o != n) begin
                evs.push_back(base + k);
                evo.push_back(n != 0);
            end
        end
        mreg[i] = nv;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cycle(input bit w, input bit r, input logic [31:0] a, input logic [15:0] d);
        bit was_busy;
        int mode;
        int ri;
        @(negedge clk);
        check(busy == (evs.size() != 0), "R7", "busy", 32'(busy), 32'(evs.size() != 0));
        if (evs.size() != 0) begin
            check(evt_valid == 1'b1, "R7", "evt_valid", 32'(evt_valid), 32'd1);
            check(int'(evt_src) == evs[0], "R5", "evt_src", 32'(evt_src), 32'(evs[0]));
            check(evt_on == evo[0], "R6", "evt_on", 32'(evt_on), 32'(evo[0]));
        end else begin
            check(evt_valid == 1'b0, "R6", "evt_valid idle", 32'(evt_valid), 32'd0);
        end
        check(err == merr, "R10", "err", 32'(err), 32'(merr));
        if (rd_pend) check(rdata == rd_exp, "R9", "rdata", 32'(rdata), 32'(rd_exp));
        if (tag_pend) check(rdata == tag_exp, tag_name, "rdata named", 32'(rdata), 32'(tag_exp));
        tag_pend = 1'b0;
        wr_en = w;
        rd_en = r;
        addr  = a;
        wdata = d;
        rd_pend = r;
        if (r) begin
            ri = find_reg(a, mode);
            rd_exp = (ri < 0) ? 16'h0 : mreg[ri];
        end
        was_busy = evs.size() != 0;
        if (was_busy) begin
            void'(evs.pop_front());
            void'(evo.pop_front());
        end
        if (w && !was_busy) model_write(a, d);
    endtask

    task automatic expect_read(input logic [31:0] a, input logic [15:0] exp, input string tag);
        cycle(1'b0, 1'b1, a, 16'h0);
        tag_pend = 1'b1;
        tag_exp  = exp;
        tag_name = tag;
    endtask

    task automatic wait_idle();
        while (evs.size() != 0) cycle(1'b0, 1'b0, 32'h0, 16'h0);
    endtask

    task automatic wr(input logic [31:0] a, input logic [15:0] d);
        cycle(1'b1, 1'b0, a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 4; i++) mreg[i] = 16'h0;
        merr = 1'b0;
        rd_pend = 1'b0;
        tag_pend = 1'b0;
        rst = 1'b1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        addr = 32'h0;
        wdata = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0 && err == 1'b0 && evt_valid == 1'b0, "R11", "outputs after reset",
              {busy, err, evt_valid}, 32'd0);
        for (int i = 0; i < 4; i++) expect_read(32'h400 + 32'(8 * i), 16'h0, "R11");

        // set alias merges, events for fields 0 and 15
        wr(32'h400, 16'h8001);
        wait_idle();
        expect_read(32'h400, 16'h8001, "R2");
        // top address bits ignored
        wr(32'hE000_0400, 16'h0100);
        wait_idle();
        expect_read(32'h400, 16'h8101, "R1");
        expect_read(32'hA000_0404, 16'h8101, "R9");
        // clear alias
        wr(32'h404, 16'h8000);
        wait_idle();
        expect_read(32'h400, 16'h0101, "R3");
        // write during busy is discarded
        wr(32'h408, 16'hFFFF);
        wr(32'h40C, 16'hFFFF);
        wr(32'h40C, 16'h00F0);
        wait_idle();
        expect_read(32'h408, 16'hFFFF, "R8");
        // priority register with set and clear aliases
        wr(32'h410, 16'h1203);
        wait_idle();
        expect_read(32'h410, 16'h1203, "R2");
        wr(32'h414, 16'h0200);
        wait_idle();
        expect_read(32'h414, 16'h1003, "R3");
        wr(32'h410, 16'h2000);
        wait_idle();
        expect_read(32'h410, 16'h3003, "R6");
        // plain priority register
        wr(32'h418, 16'hA000);
        wait_idle();
        expect_read(32'h418, 16'hA000, "R4");
        wr(32'h418, 16'h0500);
        wait_idle();
        expect_read(32'h418, 16'h0500, "R4");
        wr(32'h418, 16'h0500);
        cycle(1'b0, 1'b0, 32'h0, 16'h0);
        check(busy == 1'b0, "R7", "no busy on unchanged write", 32'(busy), 32'd0);
        // unmapped write and read
        wr(32'h41C, 16'h1234);
        cycle(1'b0, 1'b0, 32'h0, 16'h0);
        check(err == 1'b1, "R10", "err after unmapped write", 32'(err), 32'd1);
        expect_read(32'h41C, 16'h0, "R9");
        expect_read(32'h418, 16'h0500, "R10");

        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            logic [15:0] r, d;
            logic [31:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d = lfsr;
            a = (32'h400 + {27'h0, r[4:2], 2'b00}) | {r[15:13], 29'h0};
            case (r[1:0])
                2'd0, 2'd1: cycle(1'b1, 1'b0, a, d);
                2'd2:       cycle(1'b0, 1'b1, a, 16'h0);
                default:    cycle(1'b0, 1'b0, 32'h0, 16'h0);
            endcase
        end
        wait_idle();
        for (int i = 0; i < 4; i++) expect_read(32'h400 + 32'(8 * i), mreg[i], "R9");
        cycle(1'b0, 1'b0, 32'h0, 16'h0);
        cycle(1'b0, 1'b0, 32'h0, 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule